// File: doc/BRIEF.md
# Strided Banked Vector Load Unit

This unit fetches the elements of one vector from an interleaved memory of power-of-two many single-ported banks. A load is started with a base address, a stride and an element count. Element `i` lives at `base + i*stride`, and its bank is the address modulo the bank count, taken from the low address bits. After it serves an access, a bank stays occupied for a fixed number of cycles. Requests leave strictly in element order, so a request whose bank is still occupied holds back the whole stream until that bank is free. This makes the load time depend on the stride. Stride 1 on the default configuration never waits. Strides that fold back onto a few banks, and stride 0, wait on nearly every element.

The memory answers each request a fixed number of cycles after it was issued. The unit tracks those returns with a delay line and writes each returned word, with its element index, through a write port into a vector destination buffer. A `done_o` pulse follows the last write by one cycle.

The controller has four states. In IDLE it waits for `start_i`. It takes IDLE→ISSUE on a start with a non-zero count, and IDLE→DONE on a start with a count of zero. It stays in ISSUE while requests go out and takes ISSUE→DRAIN when the last element's request leaves. It stays in DRAIN while returns are still outstanding and takes DRAIN→DONE on the last write. DONE→IDLE is unconditional.

Top module: `strided_vec_load`

## Requirements
- R1: Each load issues exactly `len_i` requests on `mreq_valid_o`/`mreq_addr_o`, in element order. The address of request `i` is `base_i + i*stride_i`, taken modulo 2^ADDR_W.
- R2: `mreq_bank_o` equals the low log2(NUM_BANKS) bits of `mreq_addr_o`. The default is the low 3 bits.
- R3: A request to a bank is followed by no request to that same bank for the next BUSY_CYCLES-1 cycles (5 by default). A request waits exactly until its bank is free. Later elements never overtake it.
- R4: The first request goes out in the cycle after the cycle in which `start_i` is sampled, provided its bank is free. Requests that do not wait go out one per cycle.
- R5: The data for element `i` is taken from `mrsp_data_i` exactly MEM_LATENCY cycles (12) after its request. In that same cycle `wr_en_o` is high, `wr_idx_o` is `i` and `wr_data_o` carries that data. Writes occur strictly in index order.
- R6: `done_o` is a one-cycle pulse in the cycle after the last write. Measured from the first request cycle to the `done_o` cycle, a 64-element load takes 76 cycles with stride 1, and 391 cycles with stride 32 or stride 0.
- R7: `start_i` is ignored while a load is in progress. Neither the requests nor the written data of the current load change.
- R8: A start with `len_i` = 0 issues no request and no write, and pulses `done_o` in the cycle after the start.
- R9: During reset, `mreq_valid_o`, `wr_en_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a load when the unit is idle |
| base_i | input | ADDR_W | Address of element 0 |
| stride_i | input | ADDR_W | Address step between elements |
| len_i | input | LEN_W | Element count, 0 to MAX_VL |
| mreq_valid_o | output | 1 | A request is issued this cycle |
| mreq_addr_o | output | ADDR_W | Element address of the request |
| mreq_bank_o | output | BANK_W | Target bank of the request |
| mrsp_data_i | input | DATA_W | Memory read data, MEM_LATENCY cycles after the request |
| wr_en_o | output | 1 | Write strobe into the destination buffer |
| wr_idx_o | output | IDX_W | Element index being written |
| wr_data_o | output | DATA_W | Element data being written |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The bench targets the following cases:

- **Stride 32 and stride 0.** Every access lands on one bank. A bank counter that released one cycle early or late would shift every later request, and the total would miss 391.
- **Stride 6.** The stream revisits a bank every four elements and so waits part of the time. A design that let a free bank's element overtake the one that is waiting would produce indices out of order.
- **Zero-length load.** A design that sent a stray request or delayed `done_o` would be caught here.
- **Second start mid-load.** A design that relatched its inputs in the middle of a load would emit wrong addresses.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } vlu_state_e;

endpackage

// File: rtl/vlu_bank_busy.sv
module vlu_bank_busy #(
    parameter int NUM_BANKS   = 8,
    parameter int BUSY_CYCLES = 6,
    parameter int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic                 acc_valid_i,
    input  logic [BANK_W-1:0]    acc_bank_i,
    output logic [NUM_BANKS-1:0] bank_free_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk_i) begin
            if (!rst_n_i) begin
                cnt_q <= '0;
            end else if (acc_valid_i && (acc_bank_i == BANK_W'(g))) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end

        assign bank_free_o[g] = (cnt_q == '0);
    end

    AST_NO_BUSY_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        acc_valid_i |-> bank_free_o[acc_bank_i]); // R3

    if (BUSY_CYCLES > 1) begin : g_chk
        AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            acc_valid_i |=> !(acc_valid_i && (acc_bank_i == $past(acc_bank_i)))); // R3
    end

endmodule

// File: rtl/vlu_lat_pipe.sv
module vlu_lat_pipe #(
    parameter int LAT_CYCLES = 12
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic push_i,
    output logic ret_o
);

    logic [LAT_CYCLES-1:0] sr_q;

    if (LAT_CYCLES == 1) begin : g_one
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) sr_q <= '0;
            else          sr_q <= push_i;
        end
    end else begin : g_many
        always_ff @(posedge clk_i) begin
            if (!rst_n_i) sr_q <= '0;
            else          sr_q <= {sr_q[LAT_CYCLES-2:0], push_i};
        end
    end

    assign ret_o = sr_q[LAT_CYCLES-1];

endmodule

// File: rtl/vlu_fsm.sv
module vlu_fsm
    import vlu_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int MAX_VL    = 64,
    parameter int ADDR_W    = 32,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int LEN_W     = $clog2(MAX_VL + 1),
    parameter int IDX_W     = $clog2(MAX_VL)
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [ADDR_W-1:0]    stride_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [NUM_BANKS-1:0] bank_free_i,
    input  logic                 ret_i,
    output logic                 mreq_valid_o,
    output logic [ADDR_W-1:0]    mreq_addr_o,
    output logic [BANK_W-1:0]    mreq_bank_o,
    output logic                 wr_en_o,
    output logic [IDX_W-1:0]     wr_idx_o,
    output logic                 done_o
);

    vlu_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, stride_q;
    logic [LEN_W-1:0]  len_q, iss_cnt_q, wr_cnt_q;
    logic [BANK_W-1:0] cur_bank;
    logic              issue_fire;
    logic              last_issue, last_write;

    assign cur_bank   = addr_q[BANK_W-1:0];
    assign issue_fire = (state_q == ST_ISSUE) && bank_free_i[cur_bank];
    assign last_issue = (iss_cnt_q == len_q - LEN_W'(1));
    assign last_write = ret_i && (wr_cnt_q == len_q - LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = (len_i == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (issue_fire && last_issue) state_d = ST_DRAIN;
            ST_DRAIN: if (last_write) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            addr_q    <= '0;
            stride_q  <= '0;
            len_q     <= '0;
            iss_cnt_q <= '0;
            wr_cnt_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && start_i) begin
                addr_q    <= base_i;
                stride_q  <= stride_i;
                len_q     <= len_i;
                iss_cnt_q <= '0;
                wr_cnt_q  <= '0;
            end else begin
                if (issue_fire) begin
                    addr_q    <= addr_q + stride_q;
                    iss_cnt_q <= iss_cnt_q + LEN_W'(1);
                end
                if (ret_i) begin
                    wr_cnt_q <= wr_cnt_q + LEN_W'(1);
                end
            end
        end
    end

    always_comb begin
        mreq_valid_o = 1'b0;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: mreq_valid_o = issue_fire;
            ST_DRAIN: ;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
        mreq_addr_o = addr_q;
        mreq_bank_o = cur_bank;
        wr_en_o     = ret_i;
        wr_idx_o    = wr_cnt_q[IDX_W-1:0];
    end

    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mreq_valid_o && $past(mreq_valid_o)) |-> (mreq_addr_o == $past(mreq_addr_o) + stride_q)); // R1
    AST_WR_LE_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_en_o |-> (wr_cnt_q < iss_cnt_q)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_o |=> !done_o); // R6
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q != ST_IDLE) |=> ($stable(stride_q) && $stable(len_q))); // R7

endmodule

// File: rtl/strided_vec_load.sv
module strided_vec_load #(
    parameter int NUM_BANKS   = 8,
    parameter int BUSY_CYCLES = 6,
    parameter int MEM_LATENCY = 12,
    parameter int MAX_VL      = 64,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BANK_W      = $clog2(NUM_BANKS),
    parameter int LEN_W       = $clog2(MAX_VL + 1),
    parameter int IDX_W       = $clog2(MAX_VL)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              mreq_valid_o,
    output logic [ADDR_W-1:0] mreq_addr_o,
    output logic [BANK_W-1:0] mreq_bank_o,
    input  logic [DATA_W-1:0] mrsp_data_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o
);

    logic [NUM_BANKS-1:0] bank_free;
    logic                 ret;

    vlu_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .MAX_VL    (MAX_VL),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) i_fsm (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .start_i      (start_i),
        .base_i       (base_i),
        .stride_i     (stride_i),
        .len_i        (len_i),
        .bank_free_i  (bank_free),
        .ret_i        (ret),
        .mreq_valid_o (mreq_valid_o),
        .mreq_addr_o  (mreq_addr_o),
        .mreq_bank_o  (mreq_bank_o),
        .wr_en_o      (wr_en_o),
        .wr_idx_o     (wr_idx_o),
        .done_o       (done_o)
    );

    vlu_bank_busy #(
        .NUM_BANKS   (NUM_BANKS),
        .BUSY_CYCLES (BUSY_CYCLES),
        .BANK_W      (BANK_W)
    ) i_busy (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .acc_valid_i (mreq_valid_o),
        .acc_bank_i  (mreq_bank_o),
        .bank_free_o (bank_free)
    );

    vlu_lat_pipe #(
        .LAT_CYCLES (MEM_LATENCY)
    ) i_lat (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .push_i  (mreq_valid_o),
        .ret_o   (ret)
    );

    assign wr_data_o = mrsp_data_i;

endmodule

// File: tb/test_strided_vec_load.sv
module test_strided_vec_load;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 8;
    localparam int BUSY = 6;
    localparam int LAT  = 12;
    localparam int MVL  = 64;

    typedef struct { int cyc; logic [31:0] addr; logic [2:0] bank; } req_t;
    typedef struct { int cyc; int idx; logic [63:0] data; } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  len = '0;
    logic        mreq_valid;
    logic [31:0] mreq_addr;
    logic [2:0]  mreq_bank;
    logic [63:0] mrsp_data;
    logic        wr_en;
    logic [5:0]  wr_idx;
    logic [63:0] wr_data;
    logic        done;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    req_t req_q[$];
    wr_t  wr_q[$];
    int   bank_ready[NB];
    int   exp_done;
    bit   done_armed = 0;
    bit   done_seen = 0;
    int   first_req;
    int   done_at;
    bit   summary_done = 0;
    logic [63:0] mem_pipe[LAT];

    strided_vec_load i_strided_vec_load (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .base_i(base),
        .stride_i(stride), .len_i(len), .mreq_valid_o(mreq_valid),
        .mreq_addr_o(mreq_addr), .mreq_bank_o(mreq_bank), .mrsp_data_i(mrsp_data),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] mem_fn(logic [31:0] a);
        return {a ^ 32'h5A5A_1234, ~a + 32'd77};
    endfunction

    // memory model: answers LAT cycles after the request
    always @(posedge clk) begin
        mem_pipe[0] <= mreq_valid ? mem_fn(mreq_addr) : 64'h0;
        for (int k = 1; k < LAT; k++) mem_pipe[k] <= mem_pipe[k-1];
    end
    assign mrsp_data = mem_pipe[LAT-1];

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        req_t r;
        wr_t  w;
        if (rst_n) begin
            if (mreq_valid) begin
                if (first_req < 0) first_req = cyc;
                if (req_q.size() == 0) begin
                    check(0, "R1 unexpected request", longint'(mreq_addr), -1);
                end else begin
                    r = req_q.pop_front();
                    check(mreq_addr == r.addr, "R1 address", longint'(mreq_addr), longint'(r.addr));
                    check(mreq_bank == r.bank, "R2 bank", longint'(mreq_bank), longint'(r.bank));
                    check(cyc == r.cyc, "R3 issue cycle", cyc, r.cyc);
                end
            end
            if (wr_en) begin
                if (wr_q.size() == 0) begin
                    check(0, "R5 unexpected write", longint'(wr_idx), -1);
                end else begin
                    w = wr_q.pop_front();
                    check(int'(wr_idx) == w.idx, "R5 write index", longint'(wr_idx), w.idx);
                    check(wr_data == w.data, "R5 write data", longint'(wr_data), longint'(w.data));
                    check(cyc == w.cyc, "R5 write cycle", cyc, w.cyc);
                end
            end
            if (done) begin
                check(done_armed, "R6 unexpected done", 1, 0);
                if (done_armed) check(cyc == exp_done, "R6 done cycle", cyc, exp_done);
                done_armed = 0;
                done_seen  = 1;
                done_at    = cyc;
            end
        end
    end

    // driver: computes expected stream from the bank timing rules
    task automatic run_load(logic [31:0] b, logic [31:0] s, int n, bit glitch);
        int t_prev, t, st;
        logic [31:0] a;
        @(negedge clk);
        start = 1; base = b; stride = s; len = 7'(n);
        st = cyc;
        t_prev = st;
        for (int i = 0; i < n; i++) begin
            a = b + 32'(i) * s;
            t = t_prev + 1;
            if (bank_ready[a[2:0]] > t) t = bank_ready[a[2:0]];
            bank_ready[a[2:0]] = t + BUSY;
            req_q.push_back('{t, a, a[2:0]});
            wr_q.push_back('{t + LAT, i, mem_fn(a)});
            t_prev = t;
        end
        exp_done   = (n == 0) ? st + 1 : t_prev + LAT + 1;
        done_armed = 1;
        done_seen  = 0;
        first_req  = -1;
        @(negedge clk);
        start = 0;
        if (glitch) begin
            repeat (20) @(negedge clk);
            start = 1; base = 32'h0000_0999; stride = 32'd5; len = 7'd3; // R7
            @(negedge clk);
            start = 0;
        end
        wait (done_seen);
        repeat (BUSY + 2) @(negedge clk);
        check(req_q.size() == 0, "R1 requests outstanding", req_q.size(), 0);
        check(wr_q.size() == 0, "R5 writes outstanding", wr_q.size(), 0);
        if (n > 0) check(first_req == st + 1, "R4 first request cycle", first_req, st + 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", cyc, 20000);
        finish_run();
    end

    initial begin
        for (int k = 0; k < NB; k++) bank_ready[k] = 0;
        first_req = -1;
        repeat (3) @(negedge clk);
        check(!mreq_valid, "R9 reset mreq_valid", mreq_valid, 0);
        check(!wr_en, "R9 reset wr_en", wr_en, 0);
        check(!done, "R9 reset done", done, 0);
        rst_n = 1;
        @(negedge clk);
        check(!mreq_valid && !done, "R9 idle after reset", mreq_valid, 0);

        run_load(32'h100, 32'd1, MVL, 0);
        check(done_at - first_req == 76, "R6 stride 1 load time", done_at - first_req, 76);

        run_load(32'h40, 32'd32, MVL, 1);   // also R7: start pulsed mid-load
        check(done_at - first_req == 391, "R6 stride 32 load time", done_at - first_req, 391);

        run_load(32'h3, 32'd0, MVL, 0);
        check(done_at - first_req == 391, "R6 stride 0 load time", done_at - first_req, 391);

        run_load(32'h7, 32'd6, 20, 0);      // R3 partial stalls
        run_load(32'hFFFF_FFF0, 32'd3, 10, 0); // R1 address wrap
        run_load(32'h20, 32'd1, 1, 0);
        run_load(32'h20, 32'd1, 0, 0);      // R8
        check(first_req < 0, "R8 no request on zero length", first_req, -1);
        run_load(32'h11, 32'd9, 16, 0);

        finish_run();
    end

endmodule